// File: doc/BRIEF.md
# Maskable Interrupt Vector Selector

This block collects up to sixteen maskable interrupt sources and turns them into a single request with a vector table address. Each source owns one bit of a pending-flag register and one bit of a mask register. Peripherals raise their flag bits through set-request inputs. Software reads nothing from the block. It writes either register one byte at a time, which lets it raise or drop flags and open or close masks.

A source is eligible when its flag is set and its mask bit is clear. A global enable gates the request to the processor. Among the eligible sources, the one with the lowest bit index is chosen. Its vector address comes from a table that is not linear in the index: the sixteen sources fall into four groups, and each group maps to its own region of the table.

The request leaves as a valid/ready pair. `irq_valid` is high while any eligible source exists and the enable is set, and `vector` names the current winner. A cycle with both `irq_valid` and `irq_ready` high accepts the request and clears the winner's flag at the next clock edge. `irq_ready` may be held high or low for any length of time. While the processor holds off, the offer is not frozen: a new request at a lower index takes over `vector` at once, and the vector accepted is the one shown in the accepting cycle.

Top module: `ivs_top`

## Requirements
- R1: `irq_valid` is high exactly when `master_en` is high and at least one source has its flag set and its mask bit clear. A change of `master_en` reaches `irq_valid` in the same cycle, without waiting for a clock edge.
- R2: After reset all flags are 0 and all mask bits are 1. A set request arriving before any mask write therefore never raises `irq_valid`.
- R3: When several sources are eligible, `vector` belongs to the eligible source with the lowest index.
- R4: Sources 0, 1, 2 and 3 give vectors 0x06, 0x08, 0x0A and 0x0C.
- R5: Sources 4 to 9 give vectors 0x14, 0x16, 0x18, 0x1A, 0x1C and 0x1E, in that order.
- R6: Sources 10, 11 and 12 give vectors 0x0E, 0x10 and 0x12.
- R7: Sources 13, 14 and 15 give vectors 0x20, 0x22 and 0x24.
- R8: A write with `wr_en` high replaces one byte at the next clock edge and leaves the other byte of that register unchanged. `wr_mask` selects the register: 0 for flags, 1 for mask. `wr_lane` selects the byte: 0 for bits 7:0, 1 for bits 15:8.
- R9: Each bit of `set_req` sets its flag at the next clock edge. A set request wins over a software write of 0 to the same bit in the same cycle.
- R10: A cycle with `irq_valid` and `irq_ready` both high clears the flag of the selected source at the next edge, unless `set_req` sets that bit in the same cycle. When `irq_valid` is low, `irq_ready` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Byte write strobe |
| wr_mask | input | 1 | Register select for the write: 0 flags, 1 mask |
| wr_lane | input | 1 | Byte select for the write: 0 low, 1 high |
| wr_data | input | 8 | Byte to write |
| set_req | input | 16 | Per-source request pulses from peripherals |
| master_en | input | 1 | Global enable for maskable requests |
| irq_valid | output | 1 | A request is offered |
| irq_ready | input | 1 | The processor accepts the offered request |
| vector | output | 8 | Vector table address of the winning source; 0 when none |

## Verification
A write, a set request or an acceptance changes a register at the next rising edge. The new `irq_valid` and `vector` then follow combinationally. Only `master_en` acts with no edge in between. The bench therefore drives every input one time unit after a rising edge and samples one time unit after the following rising edge. For `master_en`, it samples one time unit after changing the input, with no clock edge in between. Each sweep step waits exactly the number of edges its stimulus needs before it looks at the outputs.

// File: rtl/ivs_pkg.sv
package ivs_pkg;

  // Architectural sizes of the interrupt bank.
  localparam int unsigned IVS_SRC    = 16;
  localparam int unsigned IVS_BYTE   = 8;
  localparam int unsigned IVS_VEC_W  = 8;

  // Group boundaries (first index of each group) and table bases.
  localparam int unsigned GRP_B_FIRST = 4;
  localparam int unsigned GRP_C_FIRST = 10;
  localparam int unsigned GRP_D_FIRST = 13;
  localparam int unsigned BASE_A      = 'h06;
  localparam int unsigned BASE_B      = 'h14;
  localparam int unsigned BASE_C      = 'h0E;
  localparam int unsigned BASE_D      = 'h20;
  localparam int unsigned VEC_STEP    = 2;

  typedef enum logic {
    REG_FLAG = 1'b0,
    REG_MASK = 1'b1
  } reg_sel_e;

  // Table address of source idx; used to build constants at elaboration.
  function automatic logic [IVS_VEC_W-1:0] vec_addr(input int unsigned idx);
    int unsigned a;
    if (idx < GRP_B_FIRST)      a = BASE_A + VEC_STEP * idx;
    else if (idx < GRP_C_FIRST) a = BASE_B + VEC_STEP * (idx - GRP_B_FIRST);
    else if (idx < GRP_D_FIRST) a = BASE_C + VEC_STEP * (idx - GRP_C_FIRST);
    else                        a = BASE_D + VEC_STEP * (idx - GRP_D_FIRST);
    return a[IVS_VEC_W-1:0];
  endfunction

endpackage

// File: rtl/ivs_regfile.sv
module ivs_regfile #(
  parameter int unsigned NUM_SRC = ivs_pkg::IVS_SRC,
  parameter int unsigned BYTE_W  = ivs_pkg::IVS_BYTE,
  localparam int unsigned NUM_LANES = NUM_SRC / BYTE_W,
  localparam int unsigned LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  ivs_pkg::reg_sel_e  wr_reg,
  input  logic [LANE_W-1:0]  wr_lane,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic [NUM_SRC-1:0] set_req,
  input  logic [NUM_SRC-1:0] clr_req,
  output logic [NUM_SRC-1:0] flag_q,
  output logic [NUM_SRC-1:0] mask_q
);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int unsigned LO = g * BYTE_W;
    logic              hit;
    logic [BYTE_W-1:0] flag_d;
    logic [BYTE_W-1:0] mask_d;

    assign hit = wr_en && (wr_lane == LANE_W'(g));

    always_comb begin
      flag_d = flag_q[LO +: BYTE_W];
      mask_d = mask_q[LO +: BYTE_W];
      if (hit && wr_reg == ivs_pkg::REG_FLAG) flag_d = wr_data;
      if (hit && wr_reg == ivs_pkg::REG_MASK) mask_d = wr_data;
      // Acceptance clear first, then peripheral set, so a set wins.
      flag_d = (flag_d & ~clr_req[LO +: BYTE_W]) | set_req[LO +: BYTE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[LO +: BYTE_W] <= '0;
        mask_q[LO +: BYTE_W] <= '1;
      end else begin
        flag_q[LO +: BYTE_W] <= flag_d;
        mask_q[LO +: BYTE_W] <= mask_d;
      end
    end
  end

endmodule

// File: rtl/ivs_pick.sv
module ivs_pick #(
  parameter int unsigned NUM_SRC = ivs_pkg::IVS_SRC
) (
  input  logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] grant,
  output logic               any
);

  // Lowest set bit: isolate with two's complement.
  assign grant = pend & (~pend + NUM_SRC'(1));
  assign any   = |pend;

endmodule

// File: rtl/ivs_vecmap.sv
module ivs_vecmap #(
  parameter int unsigned NUM_SRC = ivs_pkg::IVS_SRC,
  parameter int unsigned VEC_W   = ivs_pkg::IVS_VEC_W
) (
  input  logic [NUM_SRC-1:0] grant,
  output logic [VEC_W-1:0]   vector
);

  logic [VEC_W-1:0] part [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam logic [VEC_W-1:0] ADDR = VEC_W'(ivs_pkg::vec_addr(g));
    assign part[g] = grant[g] ? ADDR : '0;
  end

  always_comb begin
    vector = '0;
    for (int i = 0; i < NUM_SRC; i++) vector = vector | part[i];
  end

endmodule

// File: rtl/ivs_top.sv
module ivs_top #(
  parameter int unsigned NUM_SRC = ivs_pkg::IVS_SRC,
  parameter int unsigned BYTE_W  = ivs_pkg::IVS_BYTE,
  parameter int unsigned VEC_W   = ivs_pkg::IVS_VEC_W,
  localparam int unsigned NUM_LANES = NUM_SRC / BYTE_W,
  localparam int unsigned LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_mask,
  input  logic [LANE_W-1:0]  wr_lane,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic [NUM_SRC-1:0] set_req,
  input  logic               master_en,
  output logic               irq_valid,
  input  logic               irq_ready,
  output logic [VEC_W-1:0]   vector
);

  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] grant;
  logic [NUM_SRC-1:0] clr_req;
  logic               any;
  ivs_pkg::reg_sel_e  wr_reg;

  assign wr_reg = wr_mask ? ivs_pkg::REG_MASK : ivs_pkg::REG_FLAG;

  ivs_regfile #(.NUM_SRC(NUM_SRC), .BYTE_W(BYTE_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_reg (wr_reg),
    .wr_lane(wr_lane),
    .wr_data(wr_data),
    .set_req(set_req),
    .clr_req(clr_req),
    .flag_q (flag_q),
    .mask_q (mask_q)
  );

  assign pend = flag_q & ~mask_q;

  ivs_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .pend (pend),
    .grant(grant),
    .any  (any)
  );

  ivs_vecmap #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_map (
    .grant (grant),
    .vector(vector)
  );

  assign irq_valid = master_en && any;
  assign clr_req   = (irq_valid && irq_ready) ? grant : '0;

endmodule

// File: rtl/ivs_chk.sv
module ivs_chk #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned VEC_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               wr_mask,
  input logic               wr_lane,
  input logic [NUM_SRC-1:0] set_req,
  input logic               master_en,
  input logic               irq_valid,
  input logic               irq_ready,
  input logic [VEC_W-1:0]   vector,
  input logic [NUM_SRC-1:0] flag_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] grant
);

  localparam int unsigned HALF = NUM_SRC / 2;

  a_r1_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> master_en);

  a_r2_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_q == '1 && flag_q == '0));

  a_r3_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((flag_q & ~mask_q & (grant - NUM_SRC'(1))) == '0));

  // R4 R5 R6 R7: every table address is even and inside the table.
  a_r4_vector_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (vector[0] == 1'b0 && vector >= VEC_W'('h06) && vector <= VEC_W'('h24)));

  a_r8_flag_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_mask && !wr_lane && set_req == '0 && !irq_ready)
    |=> flag_q[NUM_SRC-1:HALF] == $past(flag_q[NUM_SRC-1:HALF]));

  a_r8_mask_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mask && wr_lane) |=> mask_q[HALF-1:0] == $past(mask_q[HALF-1:0]));

  a_r9_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req != '0) |=> ((flag_q & $past(set_req)) == $past(set_req)));

  a_r10_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready && !wr_en && ((set_req & grant) == '0))
    |=> ((flag_q & $past(grant)) == '0));

endmodule

bind ivs_top ivs_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_mask  (wr_mask),
  .wr_lane  (wr_lane[0]),
  .set_req  (set_req),
  .master_en(master_en),
  .irq_valid(irq_valid),
  .irq_ready(irq_ready),
  .vector   (vector),
  .flag_q   (flag_q),
  .mask_q   (mask_q),
  .grant    (grant)
);

// File: tb/sim_ivs_top.sv
module sim_ivs_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_mask = 1'b0;
  logic [0:0]  wr_lane = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] set_req = '0;
  logic        master_en = 1'b0;
  logic        irq_ready = 1'b0;
  logic        irq_valid;
  logic [7:0]  vector;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ivs_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask), .wr_lane(wr_lane),
    .wr_data(wr_data), .set_req(set_req), .master_en(master_en),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .vector(vector)
  );

  function automatic logic [7:0] vexp(input int i);
    if (i < 4)       return 8'(6 + 2 * i);
    else if (i < 10) return 8'('h14 + 2 * (i - 4));
    else if (i < 13) return 8'('h0E + 2 * (i - 10));
    else             return 8'('h20 + 2 * (i - 13));
  endfunction

  function automatic string grp(input int i);
    if (i < 4)       return "R4";
    else if (i < 10) return "R5";
    else if (i < 13) return "R6";
    else             return "R7";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic m, input logic ln, input logic [7:0] d);
    wr_en = 1'b1; wr_mask = m; wr_lane = ln; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic pulse_set(input logic [15:0] v);
    set_req = v;
    cyc();
    set_req = '0;
  endtask

  task automatic clear_flags();
    wr(1'b0, 1'b0, 8'h00);
    wr(1'b0, 1'b1, 8'h00);
  endtask

  task automatic set_mask(input logic [15:0] m);
    wr(1'b1, 1'b0, m[7:0]);
    wr(1'b1, 1'b1, m[15:8]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    master_en = 1'b1;
    repeat (2) cyc();
    rst_n = 1'b1;
    cyc();
    // R2: nothing offered after reset
    check("R2 idle", irq_valid, 0);
    pulse_set('1);
    check("R2 all masked", irq_valid, 0);
    // R8: open low mask byte only
    wr(1'b1, 1'b0, 8'h00);
    check("R8 low open", vector, 'h06);
    wr(1'b1, 1'b0, 8'hFF);
    wr(1'b1, 1'b1, 8'h00);
    check("R8 high open keeps low", vector, vexp(8));
    check("R8 valid", irq_valid, 1);
    // R8: flag low write keeps high flags
    wr(1'b0, 1'b0, 8'h00);
    check("R8 flag high kept", vector, vexp(8));
    clear_flags();
    check("R8 flags cleared", irq_valid, 0);
    set_mask(16'h0000);

    // single-source sweep with acceptance
    for (int i = 0; i < 16; i++) begin
      pulse_set(16'(1) << i);
      check(grp(i), vector, vexp(i));
      check("R1 valid", irq_valid, 1);
      irq_ready = 1'b1;
      cyc();
      irq_ready = 1'b0;
      check("R10 accepted", irq_valid, 0);
    end

    // pair sweep: lower index wins
    for (int i = 0; i < 16; i++) begin
      for (int j = i + 1; j < 16; j++) begin
        pulse_set((16'(1) << i) | (16'(1) << j));
        check("R3 pair", vector, vexp(i));
        clear_flags();
      end
    end

    // drain all by acceptance in order
    pulse_set('1);
    irq_ready = 1'b1;
    for (int k = 0; k < 16; k++) begin
      check("R10 drain order", vector, vexp(k));
      cyc();
    end
    irq_ready = 1'b0;
    check("R10 drained", irq_valid, 0);

    // mask prefix sweep
    pulse_set('1);
    for (int k = 0; k < 16; k++) begin
      set_mask(16'((32'(1) << k) - 1));
      check("R3 mask prefix", vector, vexp(k));
    end
    set_mask(16'hFFFF);
    check("R1 all masked", irq_valid, 0);
    set_mask(16'h0000);
    clear_flags();

    // R1: enable acts without a clock edge
    pulse_set(16'h0008);
    master_en = 1'b0;
    #1;
    check("R1 disabled", irq_valid, 0);
    master_en = 1'b1;
    #1;
    check("R1 enabled", irq_valid, 1);
    clear_flags();

    // R9: set wins over software clear
    pulse_set(16'h0020);
    set_req = 16'h0020;
    wr(1'b0, 1'b0, 8'h00);
    set_req = '0;
    check("R9 set beats clear", vector, vexp(5));
    set_req = 16'h0004;
    wr(1'b0, 1'b0, 8'h00);
    set_req = '0;
    check("R9 set with write", vector, vexp(2));

    // R10: set wins over acceptance of the same bit
    set_req = 16'h0004;
    irq_ready = 1'b1;
    cyc();
    set_req = '0;
    irq_ready = 1'b0;
    check("R10 set beats accept", vector, vexp(2));

    // R10: ready without valid has no effect
    master_en = 1'b0;
    irq_ready = 1'b1;
    cyc();
    irq_ready = 1'b0;
    master_en = 1'b1;
    #1;
    check("R10 ready ignored", vector, vexp(2));
    check("R10 still valid", irq_valid, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule